// File: doc/BRIEF.md
# Serial EEPROM Single-Byte Transaction Sequencer

This block turns one host request into a complete two-wire bus transaction on a 2-kbit serial EEPROM. The EEPROM has 256 bytes and takes a one-byte memory address. The block can do a single-byte write or a random single-byte read. It does not drive the bus wires itself. It hands a series of primitive commands to a lower bit engine: start condition, stop condition, write a byte, and read a byte. It sends one command at a time and waits for the engine's completion pulse before it sends the next.

For a write, the block first sends a start condition. It then sends the device word marked for writing, the memory address and the data byte, and it checks the acknowledge after each byte. For a read, it sends the address phase and then a repeated start. It follows with the device word marked for reading and reads one byte, answering that byte with a not-acknowledge. Both transactions end with a stop condition.

If any byte the block writes comes back without an acknowledge, the block gives up. It raises its error flag, sends the stop condition at once and skips the bytes still pending. It then signals completion as usual.

Top module: `eeseq_top`

## Requirements
- R1: After reset the block issues no command (`cmdValid` low), and `rspDone` and `rspErr` are both low.
- R2: The device word has the fixed code 1010 in bits 7:4 and the request's select bits in bits 3:1. Bit 0 is 0 for the write direction and 1 for the read direction.
- R3: A write request issues exactly these commands: START, WRITE(device word for write), WRITE(memory address), WRITE(data byte), STOP. The command codes on `cmdOp` are START=1, STOP=2, WRITE=3 and READ=4.
- R4: A read request issues exactly these commands: START, WRITE(device word for write), WRITE(memory address), START, WRITE(device word for read), READ, STOP. The READ command carries `cmdNack`=1. After the transaction, `rspRdData` holds the byte the engine returned.
- R5: An acknowledge bit of 0 after every written byte means success, and `rspErr` stays 0 for that transaction.
- R6: An acknowledge bit of 1 after any written byte sets `rspErr`. The next command is then STOP, and no further bytes of that transaction are written.
- R7: Each command is a single-cycle `cmdValid` pulse. No new command is issued until `engDone` has answered the previous one.
- R8: `rspDone` is a single-cycle pulse, given only after the final STOP has completed. `rspErr` holds its value until the next request is accepted, and a successful request clears it.
- R9: A request presented while a transaction is in progress is ignored. The commands and bytes of the running transaction are unchanged, and no further transaction follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken only while idle |
| reqRead | input | 1 | 1 for a random read, 0 for a byte write |
| reqDevSel | input | SEL_W | Device select bits for the device word |
| reqAddr | input | BYTE_W | Memory address |
| reqWrData | input | BYTE_W | Data byte for a write |
| rspDone | output | 1 | One-cycle pulse at the end of a transaction |
| rspErr | output | 1 | Set when an acknowledge was missing |
| rspRdData | output | BYTE_W | Byte returned by the last read |
| cmdValid | output | 1 | Command strobe to the bit engine |
| cmdOp | output | 3 | Command code: 1 start, 2 stop, 3 write, 4 read |
| cmdData | output | BYTE_W | Byte to send for a write command |
| cmdNack | output | 1 | Acknowledge level the master returns on a read (1 = not-acknowledge) |
| engDone | input | 1 | Bit engine completion pulse |
| engAckBit | input | 1 | Acknowledge sampled after a written byte (0 = acknowledged) |
| engRdData | input | BYTE_W | Byte received by a read command |

## Verification
The bench drives the block with a small bit-engine model that also behaves as an EEPROM. The model acknowledges only the device word that carries its own select bits, and it stores and returns real bytes.

- **Clean write, then clean read.** A write is followed by a read of the same address. This separates the two command sequences and the position of the direction bit, and it shows that the read data really comes back from the engine.
- **Wrong select bits.** These trigger a not-acknowledge on the device word, so the abort after the first byte can be seen.
- **Forced not-acknowledge on a later byte.** A not-acknowledge forced on the data byte, or on the address byte of a read, shows that the abort can happen at any byte position.
- **Request while busy.** A second request with different fields, sent while a write is running, shows whether the captured request stays isolated.

// File: rtl/eeseq_pkg.sv
package eeseq_pkg;

  // Command codes presented to the bit engine.
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_START = 3'd1,
    OP_STOP  = 3'd2,
    OP_WRITE = 3'd3,
    OP_READ  = 3'd4
  } busOp_e;

  // Which byte the datapath drives onto the command data lines.
  typedef enum logic [1:0] {
    BYTE_DEVW,
    BYTE_DEVR,
    BYTE_ADDR,
    BYTE_DATA
  } byteSel_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic     capture;
    logic     setErr;
    logic     loadRd;
    byteSel_e byteSel;
  } dpStrobe_t;

endpackage

// File: rtl/eeseq_ctrl.sv
module eeseq_ctrl
  import eeseq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqRead,
  input  logic      engDone,
  input  logic      engAckBit,
  output logic      cmdValid,
  output logic [2:0] cmdOp,
  output logic      cmdNack,
  output logic      rspDone,
  output dpStrobe_t strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_FINISH} state_e;

  // One step per bus command; the order is the transaction order.
  typedef enum logic [2:0] {
    STEP_START,
    STEP_DEVW,
    STEP_ADDR,
    STEP_DATA,
    STEP_RSTART,
    STEP_DEVR,
    STEP_READ,
    STEP_STOP
  } step_e;

  state_e state;
  step_e  step;
  logic   isRead;
  busOp_e curOp;
  step_e  followStep;

  // Command code for the current step.
  always_comb begin
    unique case (step)
      STEP_START, STEP_RSTART: curOp = OP_START;
      STEP_STOP:               curOp = OP_STOP;
      STEP_READ:               curOp = OP_READ;
      default:                 curOp = OP_WRITE;
    endcase
  end

  // Step that follows the current one on the success path.
  always_comb begin
    unique case (step)
      STEP_START:  followStep = STEP_DEVW;
      STEP_DEVW:   followStep = STEP_ADDR;
      STEP_ADDR:   followStep = isRead ? STEP_RSTART : STEP_DATA;
      STEP_RSTART: followStep = STEP_DEVR;
      STEP_DEVR:   followStep = STEP_READ;
      default:     followStep = STEP_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      step   <= STEP_START;
      isRead <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            isRead <= reqRead;
            step   <= STEP_START;
            state  <= ST_ISSUE;
          end
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: begin
          if (engDone) begin
            if (step == STEP_STOP) begin
              state <= ST_FINISH;
            end else if (curOp == OP_WRITE && engAckBit) begin
              step  <= STEP_STOP;
              state <= ST_ISSUE;
            end else begin
              step  <= followStep;
              state <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Strobes for the datapath.
  always_comb begin
    strobe.capture = (state == ST_IDLE) && reqValid;
    strobe.setErr  = (state == ST_WAIT) && engDone && (curOp == OP_WRITE) && engAckBit;
    strobe.loadRd  = (state == ST_WAIT) && engDone && (step == STEP_READ);
    unique case (step)
      STEP_DEVR: strobe.byteSel = BYTE_DEVR;
      STEP_ADDR: strobe.byteSel = BYTE_ADDR;
      STEP_DATA: strobe.byteSel = BYTE_DATA;
      default:   strobe.byteSel = BYTE_DEVW;
    endcase
  end

  // Outputs to the bit engine and to the host.
  assign cmdValid = (state == ST_ISSUE);
  assign cmdOp    = curOp;
  assign cmdNack  = (step == STEP_READ);
  assign rspDone  = (state == ST_FINISH);

endmodule

// File: rtl/eeseq_datapath.sv
module eeseq_datapath
  import eeseq_pkg::*;
#(
  parameter int SEL_W  = 3,
  parameter int BYTE_W = 8,
  parameter int CODE_W = BYTE_W - SEL_W - 1,
  parameter logic [CODE_W-1:0] DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [SEL_W-1:0]  reqDevSel,
  input  logic [BYTE_W-1:0] reqAddr,
  input  logic [BYTE_W-1:0] reqWrData,
  input  logic [BYTE_W-1:0] engRdData,
  output logic [BYTE_W-1:0] cmdData,
  output logic              rspErr,
  output logic [BYTE_W-1:0] rspRdData
);

  logic [SEL_W-1:0]  selReg;
  logic [BYTE_W-1:0] addrReg;
  logic [BYTE_W-1:0] dataReg;
  logic [BYTE_W-2:0] devBase;

  // Request holding registers; loaded only when a request is taken.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg  <= '0;
      addrReg <= '0;
      dataReg <= '0;
    end else if (strobe.capture) begin
      selReg  <= reqDevSel;
      addrReg <= reqAddr;
      dataReg <= reqWrData;
    end
  end

  // Error flag: cleared when a request is taken, set on a missing acknowledge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspErr <= 1'b0;
    end else if (strobe.capture) begin
      rspErr <= 1'b0;
    end else if (strobe.setErr) begin
      rspErr <= 1'b1;
    end
  end

  // Read data register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspRdData <= '0;
    end else if (strobe.loadRd) begin
      rspRdData <= engRdData;
    end
  end

  // Device word without the direction bit: fixed code, then the select bits.
  assign devBase = {DEV_CODE, selReg};

  // Byte sent with a write command.
  always_comb begin
    unique case (strobe.byteSel)
      BYTE_DEVR: cmdData = {devBase, 1'b1};
      BYTE_ADDR: cmdData = addrReg;
      BYTE_DATA: cmdData = dataReg;
      default:   cmdData = {devBase, 1'b0};
    endcase
  end

endmodule

// File: rtl/eeseq_top.sv
module eeseq_top
  import eeseq_pkg::*;
#(
  parameter int SEL_W  = 3,
  parameter int BYTE_W = 8,
  parameter int CODE_W = BYTE_W - SEL_W - 1,
  parameter logic [CODE_W-1:0] DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqRead,
  input  logic [SEL_W-1:0]  reqDevSel,
  input  logic [BYTE_W-1:0] reqAddr,
  input  logic [BYTE_W-1:0] reqWrData,
  output logic              rspDone,
  output logic              rspErr,
  output logic [BYTE_W-1:0] rspRdData,
  output logic              cmdValid,
  output logic [2:0]        cmdOp,
  output logic [BYTE_W-1:0] cmdData,
  output logic              cmdNack,
  input  logic              engDone,
  input  logic              engAckBit,
  input  logic [BYTE_W-1:0] engRdData
);

  dpStrobe_t strobe;

  eeseq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqRead   (reqRead),
    .engDone   (engDone),
    .engAckBit (engAckBit),
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp),
    .cmdNack   (cmdNack),
    .rspDone   (rspDone),
    .strobe    (strobe)
  );

  eeseq_datapath #(
    .SEL_W    (SEL_W),
    .BYTE_W   (BYTE_W),
    .CODE_W   (CODE_W),
    .DEV_CODE (DEV_CODE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqDevSel (reqDevSel),
    .reqAddr   (reqAddr),
    .reqWrData (reqWrData),
    .engRdData (engRdData),
    .cmdData   (cmdData),
    .rspErr    (rspErr),
    .rspRdData (rspRdData)
  );

endmodule

// File: rtl/eeseq_checker.sv
module eeseq_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [2:0]        cmdOp,
  input logic [BYTE_W-1:0] cmdData,
  input logic              cmdNack,
  input logic              engDone,
  input logic              engAckBit,
  input logic              rspDone
);

  localparam logic [2:0] C_START = 3'd1;
  localparam logic [2:0] C_STOP  = 3'd2;
  localparam logic [2:0] C_WRITE = 3'd3;
  localparam logic [2:0] C_READ  = 3'd4;

  logic [2:0] lastOp;
  logic       waitEng;
  logic       afterStart;
  logic       pendAbort;

  // Observation state built from the ports only.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastOp     <= 3'd0;
      waitEng    <= 1'b0;
      afterStart <= 1'b0;
      pendAbort  <= 1'b0;
    end else begin
      if (cmdValid) begin
        lastOp     <= cmdOp;
        afterStart <= (cmdOp == C_START);
        pendAbort  <= 1'b0;
        waitEng    <= 1'b1;
      end else if (engDone) begin
        waitEng <= 1'b0;
        if (lastOp == C_WRITE && engAckBit) pendAbort <= 1'b1;
      end
    end
  end

  // R7: each command strobe lasts one cycle
  p_cmd_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // R7: no command while the engine still owes a completion
  p_one_outstanding_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !waitEng);

  // R2: the first byte after a start carries the fixed device code
  p_dev_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && afterStart && cmdOp == C_WRITE) |-> (cmdData[BYTE_W-1 -: 4] == 4'b1010));

  // R6: a missing acknowledge is followed directly by a stop
  p_abort_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && pendAbort) |-> (cmdOp == C_STOP));

  // R4: a read command always asks for a not-acknowledge
  p_read_nack_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == C_READ) |-> cmdNack);

  // R8: completion only after a stop, as a single-cycle pulse
  p_done_after_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> (lastOp == C_STOP && !waitEng));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

endmodule

bind eeseq_top eeseq_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmdValid  (cmdValid),
  .cmdOp     (cmdOp),
  .cmdData   (cmdData),
  .cmdNack   (cmdNack),
  .engDone   (engDone),
  .engAckBit (engAckBit),
  .rspDone   (rspDone)
);

// File: tb/eeseq_top_test.sv
`timescale 1ns/1ps
module eeseq_top_test;

  localparam int OP_START = 1;
  localparam int OP_STOP  = 2;
  localparam int OP_WRITE = 3;
  localparam int OP_READ  = 4;
  localparam logic [2:0] SLAVE_SEL = 3'b101;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqRead = 1'b0;
  logic [2:0] reqDevSel = '0;
  logic [7:0] reqAddr = '0;
  logic [7:0] reqWrData = '0;
  logic       rspDone, rspErr;
  logic [7:0] rspRdData;
  logic       cmdValid, cmdNack;
  logic [2:0] cmdOp;
  logic [7:0] cmdData;
  logic       engDone = 1'b0;
  logic       engAckBit = 1'b0;
  logic [7:0] engRdData = '0;

  eeseq_top uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRead(reqRead),
    .reqDevSel(reqDevSel), .reqAddr(reqAddr), .reqWrData(reqWrData),
    .rspDone(rspDone), .rspErr(rspErr), .rspRdData(rspRdData),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdData(cmdData), .cmdNack(cmdNack),
    .engDone(engDone), .engAckBit(engAckBit), .engRdData(engRdData)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  // Command log filled by the engine model.
  int       logN = 0;
  int       logOp [0:15];
  int       logData [0:15];
  int       logNack [0:15];
  // Expected sequence.
  int       expN = 0;
  int       expOp [0:15];
  int       expData [0:15];

  // Engine and EEPROM model.
  logic [7:0] mem [0:255];
  int   cnt = 0;
  int   wrIdx = 0;
  int   gIdx = 0;
  int   forceNack = -1;
  bit   rdMode = 0;
  logic [7:0] ptr = '0;
  logic       pendAck = 1'b0;
  logic [7:0] pendRd = '0;

  always @(negedge clk) begin
    engDone = 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        engDone   = 1'b1;
        engAckBit = pendAck;
        engRdData = pendRd;
      end
    end else if (cmdValid) begin
      if (logN < 16) begin
        logOp[logN]   = int'(cmdOp);
        logData[logN] = int'(cmdData);
        logNack[logN] = int'(cmdNack);
      end
      logN++;
      pendAck = 1'b0;
      if (cmdOp == 3'(OP_START)) wrIdx = 0;
      else if (cmdOp == 3'(OP_READ)) begin
        pendRd  = mem[ptr];
        pendAck = 1'b1;
      end else if (cmdOp == 3'(OP_WRITE)) begin
        if (wrIdx == 0) begin
          pendAck = (cmdData[7:1] != {4'b1010, SLAVE_SEL});
          rdMode  = cmdData[0];
        end else if (wrIdx == 1 && !rdMode) ptr = cmdData;
        else if (wrIdx == 2 && !rdMode) mem[ptr] = cmdData;
        if (gIdx == forceNack) pendAck = 1'b1;
        gIdx++;
        wrIdx++;
      end
      cnt = 3;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expPush(input int op, input int data);
    expOp[expN] = op;
    expData[expN] = data;
    expN++;
  endtask

  task automatic checkSeq(input string req);
    check(logN == expN, req, "command count", logN, expN);
    for (int i = 0; i < expN && i < logN; i++) begin
      check(logOp[i] == expOp[i], req, $sformatf("op %0d", i), logOp[i], expOp[i]);
      if (expOp[i] == OP_WRITE)
        check(logData[i] == expData[i], req, $sformatf("byte %0d", i), logData[i], expData[i]);
    end
  endtask

  // Issue one request and wait for completion; checks the pulse width (R8).
  task automatic runReq(input bit rd, input logic [2:0] sel, input logic [7:0] addr,
                        input logic [7:0] data, input int nackAt);
    int waitCnt;
    @(negedge clk);
    logN = 0; gIdx = 0; expN = 0; forceNack = nackAt;
    reqValid = 1'b1; reqRead = rd; reqDevSel = sel; reqAddr = addr; reqWrData = data;
    @(negedge clk);
    reqValid = 1'b0;
    waitCnt = 0;
    while (!rspDone && waitCnt < 300) begin
      @(negedge clk);
      waitCnt++;
    end
    check(rspDone == 1'b1, "R8", "done seen", int'(rspDone), 1);
    @(negedge clk);
    check(rspDone == 1'b0, "R8", "done one cycle", int'(rspDone), 0);
  endtask

  task automatic testReset();
    check(cmdValid == 1'b0, "R1", "cmdValid after reset", int'(cmdValid), 0);
    check(rspDone == 1'b0, "R1", "rspDone after reset", int'(rspDone), 0);
    check(rspErr == 1'b0, "R1", "rspErr after reset", int'(rspErr), 0);
  endtask

  task automatic testWrite();
    runReq(1'b0, SLAVE_SEL, 8'h3C, 8'hA5, -1);
    expPush(OP_START, 0); expPush(OP_WRITE, 8'hAA); expPush(OP_WRITE, 8'h3C);
    expPush(OP_WRITE, 8'hA5); expPush(OP_STOP, 0);
    checkSeq("R3");
    check(rspErr == 1'b0, "R5", "error after clean write", int'(rspErr), 0);
    check(mem[8'h3C] == 8'hA5, "R3", "stored byte", int'(mem[8'h3C]), 8'hA5);
  endtask

  task automatic testRead();
    mem[8'h71] = 8'h5E;
    runReq(1'b1, SLAVE_SEL, 8'h71, 8'h00, -1);
    expPush(OP_START, 0); expPush(OP_WRITE, 8'hAA); expPush(OP_WRITE, 8'h71);
    expPush(OP_START, 0); expPush(OP_WRITE, 8'hAB); expPush(OP_READ, 0);
    expPush(OP_STOP, 0);
    checkSeq("R4");
    check(logNack[5] == 1, "R4", "nack on read", logNack[5], 1);
    check(rspRdData == 8'h5E, "R4", "read data", int'(rspRdData), 8'h5E);
    check(rspErr == 1'b0, "R5", "error after clean read", int'(rspErr), 0);
    // Read back the byte written earlier.
    runReq(1'b1, SLAVE_SEL, 8'h3C, 8'h00, -1);
    check(rspRdData == 8'hA5, "R4", "read back", int'(rspRdData), 8'hA5);
  endtask

  task automatic testBadSelect();
    runReq(1'b0, 3'b010, 8'h10, 8'h77, -1);
    expPush(OP_START, 0); expPush(OP_WRITE, 8'hA4); expPush(OP_STOP, 0);
    checkSeq("R6");
    check(rspErr == 1'b1, "R6", "error on device nack", int'(rspErr), 1);
    check(mem[8'h10] != 8'h77, "R6", "no write happened", int'(mem[8'h10]), 0);
  endtask

  task automatic testDataNack();
    runReq(1'b0, SLAVE_SEL, 8'h20, 8'h33, 2);
    expPush(OP_START, 0); expPush(OP_WRITE, 8'hAA); expPush(OP_WRITE, 8'h20);
    expPush(OP_WRITE, 8'h33); expPush(OP_STOP, 0);
    checkSeq("R6");
    check(rspErr == 1'b1, "R6", "error on data nack", int'(rspErr), 1);
    // A clean request clears the flag (R8).
    runReq(1'b0, SLAVE_SEL, 8'h21, 8'h44, -1);
    check(rspErr == 1'b0, "R8", "error cleared", int'(rspErr), 0);
  endtask

  task automatic testReadAddrNack();
    runReq(1'b1, SLAVE_SEL, 8'h71, 8'h00, 1);
    expPush(OP_START, 0); expPush(OP_WRITE, 8'hAA); expPush(OP_WRITE, 8'h71);
    expPush(OP_STOP, 0);
    checkSeq("R6");
    check(rspErr == 1'b1, "R6", "error on address nack", int'(rspErr), 1);
  endtask

  task automatic testBusyIgnore();
    int waitCnt;
    @(negedge clk);
    logN = 0; gIdx = 0; expN = 0; forceNack = -1;
    reqValid = 1'b1; reqRead = 1'b0; reqDevSel = SLAVE_SEL; reqAddr = 8'h40; reqWrData = 8'h9C;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (6) @(negedge clk);
    reqValid = 1'b1; reqRead = 1'b1; reqDevSel = 3'b000; reqAddr = 8'hEE; reqWrData = 8'h11;
    @(negedge clk);
    reqValid = 1'b0;
    waitCnt = 0;
    while (!rspDone && waitCnt < 300) begin
      @(negedge clk);
      waitCnt++;
    end
    repeat (20) @(negedge clk);
    expPush(OP_START, 0); expPush(OP_WRITE, 8'hAA); expPush(OP_WRITE, 8'h40);
    expPush(OP_WRITE, 8'h9C); expPush(OP_STOP, 0);
    checkSeq("R9");
    check(mem[8'h40] == 8'h9C, "R9", "original byte stored", int'(mem[8'h40]), 8'h9C);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testWrite();
    testRead();
    testBadSelect();
    testDataNack();
    testReadAddrNack();
    testBusyIgnore();
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

endmodule